// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core in which every instruction finishes in a single clock cycle. It runs six instructions: two register-to-register arithmetic operations (unsigned add and subtract), an OR with an immediate, a word load, a word store and a branch taken when two registers are equal. The core holds the program counter, a 32 by 32-bit register file, an immediate extender, an ALU and a control decoder. The decoder turns each instruction into a fixed set of control values. These values choose the destination register, the second ALU operand, the ALU operation, the write-back source, the memory write and the next-PC source.

The core sits between two word arrays that the surrounding system provides. Each cycle it presents the PC as a byte address to the instruction array and takes back the 32-bit instruction at once. The data array is used the same way: the ALU result is the byte address, reads are combinational and writes happen on the clock edge. The equality branch reads the ALU zero flag from a subtraction in the same cycle and settles the next PC before the edge.

Top module: `sc_core`

## Requirements
- R1: With `rst` high at a rising clock edge, the PC is 0 after that edge, so `imem_addr` reads 0.
- R2: Opcode 0x00 with function code 0x21 writes rs+rt into rd, and function code 0x23 writes rs-rt into rd, both modulo 2^32. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 0x0D writes rs OR the zero-extended imm16 (bits [15:0]) into rt.
- R4: Opcode 0x23 loads the data word at byte address rs+sign_extend(imm16) into rt.
- R5: Opcode 0x2B writes rt to the data word at byte address rs+sign_extend(imm16). `dmem_we` is high only while a store is being executed.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign_extend(imm16)<<2) when rs equals rt, and to PC+4 otherwise. The branch target may lie behind the branch.
- R7: Register 0 always reads as zero, and writes to it leave it zero.
- R8: Any other opcode, or opcode 0x00 with any other function code, writes no register and no memory, and the PC advances by 4.
- R9: Every instruction except a taken branch advances the PC by exactly 4 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the PC |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word read combinationally at `imem_addr` |
| dmem_addr | output | 32 | Byte address for data access (the ALU result) |
| dmem_wdata | output | 32 | Store data, the value of register rt |
| dmem_we | output | 1 | Data write enable, taken on the rising edge |
| dmem_rdata | input | 32 | Data word read combinationally at `dmem_addr` |

## Verification
Register state is hidden inside the core, so a corrupted register or a wrong write-back stays invisible until a later store copies it out to the data array. The bench stores every computed value straight after producing it, so a fault shows up as a wrong word in a known slot. A wrong branch or PC decision shows on `imem_addr` at the very next edge. A wrong control decode often shows as a bad `dmem_we` in the same cycle, and otherwise as a wrong or missing result later. The checker flags PC and write-enable faults in the cycle they occur; the memory comparison at the end catches datapath faults.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU   = 6'h21;
    localparam logic [5:0] FN_SUBU   = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    // One control vector per instruction
    typedef struct packed {
        logic    dst_rd;    // 1: write rd, 0: write rt
        logic    reg_we;    // register file write
        logic    ext_sign;  // 1: sign-extend imm16, 0: zero-extend
        logic    src_imm;   // 1: ALU B is immediate, 0: register rt
        alu_op_e alu_op;
        logic    mem_we;    // data memory write
        logic    wb_mem;    // 1: write back load data, 0: ALU result
        logic    br_sel;    // 1: branch on ALU zero
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        dst_rd: 1'b0, reg_we: 1'b0, ext_sign: 1'b0, src_imm: 1'b0,
        alu_op: ALU_ADD, mem_we: 1'b0, wb_mem: 1'b0, br_sel: 1'b0
    };

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADDU || funct == FN_SUBU) begin
                    ctrl.dst_rd  = 1'b1;
                    ctrl.reg_we  = 1'b1;
                    ctrl.src_imm = 1'b0;
                    ctrl.alu_op  = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
                end
            end
            OPC_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.ext_sign = 1'b0;
                ctrl.src_imm  = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OPC_LW: begin
                ctrl.reg_we   = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.alu_op   = ALU_ADD;
                ctrl.wb_mem   = 1'b1;
            end
            OPC_SW: begin
                ctrl.ext_sign = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.alu_op   = ALU_ADD;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.ext_sign = 1'b1;
                ctrl.alu_op   = ALU_SUB;
                ctrl.br_sel   = 1'b1;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic [IW-1:0]   ra_idx,
    input  logic [IW-1:0]   rb_idx,
    input  logic [IW-1:0]   rw_idx,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data
);

    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && rw_idx != '0) begin
            regs_d[rw_idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // Register 0 is hard-wired to zero on both read ports
    assign ra_data = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs_q[rb_idx];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int IW    = $clog2(NREG);
    localparam int IMM_W = 16;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t s_d, s_q;

    // Instruction fields
    logic [5:0]       f_op;
    logic [5:0]       f_funct;
    logic [IW-1:0]    f_rs, f_rt, f_rd;
    logic [IMM_W-1:0] f_imm;
    logic [4:0]       unused_shamt;

    assign f_op         = imem_rdata[31:26];
    assign f_rs         = imem_rdata[21+IW-1:21];
    assign f_rt         = imem_rdata[16+IW-1:16];
    assign f_rd         = imem_rdata[11+IW-1:11];
    assign unused_shamt = imem_rdata[10:6];
    assign f_funct      = imem_rdata[5:0];
    assign f_imm        = imem_rdata[IMM_W-1:0];

    ctrl_t ctrl;

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_funct),
        .ctrl   (ctrl)
    );

    logic [XLEN-1:0] bus_a, bus_b, bus_w;
    logic [XLEN-1:0] alu_b, alu_y, ext_imm;
    logic [IW-1:0]   rw_idx;
    logic            alu_zero;

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .ra_idx  (f_rs),
        .rb_idx  (f_rt),
        .rw_idx  (rw_idx),
        .we      (ctrl.reg_we),
        .wdata   (bus_w),
        .ra_data (bus_a),
        .rb_data (bus_b)
    );

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (bus_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Extender, operand and write-back selection
    logic [XLEN-1:0] sext_imm, br_off, pc_inc;

    assign sext_imm = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    assign ext_imm  = ctrl.ext_sign ? sext_imm : {{(XLEN-IMM_W){1'b0}}, f_imm};
    assign alu_b    = ctrl.src_imm ? ext_imm : bus_b;
    assign rw_idx   = ctrl.dst_rd ? f_rd : f_rt;
    assign bus_w    = ctrl.wb_mem ? dmem_rdata : alu_y;
    assign br_off   = {sext_imm[XLEN-3:0], 2'b00};
    assign pc_inc   = s_q.pc + XLEN'(4);

    // Next-state logic
    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.pc = '0;
        end else if (ctrl.br_sel && alu_zero) begin
            s_d.pc = pc_inc + br_off;
        end else begin
            s_d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign imem_addr  = s_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = bus_b;
    assign dmem_we    = ctrl.mem_we;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_rdata,
    input logic [XLEN-1:0] dmem_addr,
    input logic            dmem_we
);

    logic [5:0]      c_op;
    logic [5:0]      c_fn;
    logic            c_beq, c_known;
    logic [XLEN-1:0] c_off;

    assign c_op    = imem_rdata[31:26];
    assign c_fn    = imem_rdata[5:0];
    assign c_beq   = (c_op == 6'h04);
    assign c_known = (c_op == 6'h0D) || (c_op == 6'h23) || (c_op == 6'h2B) || c_beq ||
                     ((c_op == 6'h00) && (c_fn == 6'h21 || c_fn == 6'h23));
    assign c_off   = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

    // R1: reset brings the PC to zero
    p_reset_pc_r1: assert property (@(posedge clk) rst |=> (imem_addr == '0));

    // R5: data write only during a store
    p_we_store_only_r5: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (c_op == 6'h2B));

    // R8: unknown encodings never write memory
    p_unknown_no_we_r8: assert property (@(posedge clk) disable iff (rst)
        !c_known |-> !dmem_we);

    // R9: non-branch instructions step by four
    p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
        !c_beq |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R6: untaken branch steps by four
    p_beq_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (c_beq && dmem_addr != '0) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R6: taken branch goes to PC+4+offset*4
    p_beq_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (c_beq && dmem_addr == '0) |=>
        (imem_addr == $past(imem_addr) + XLEN'(4) + $past(c_off)));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [128];
    logic [31:0] dmem [128];

    int n_chk  = 0;
    int n_fail = 0;
    int pc_n   = 0;

    always #2.5 clk = ~clk;

    sc_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[8:2]];
    assign dmem_rdata = dmem[dmem_addr[8:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[8:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        logic [4:0] a = rs[4:0];
        logic [4:0] b = rt[4:0];
        logic [4:0] d = rd[4:0];
        return {6'h00, a, b, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        logic [4:0]  a = rs[4:0];
        logic [4:0]  b = rt[4:0];
        logic [15:0] v = imm[15:0];
        return {op, a, b, v};
    endfunction

    task automatic emit(logic [31:0] w);
        imem[pc_n] = w;
        pc_n++;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] op_a(int k);
        case (k)
            0: return 32'h7FFF_FFFF;
            1: return 32'h0000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h1234_5678;
            default: return 32'h1357_9BDF * k;
        endcase
    endfunction

    function automatic logic [31:0] op_b(int k);
        case (k)
            0: return 32'h0000_0001;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h9ABC_DEF0;
            default: return 32'hFEDC_BA98 ^ (k << 5);
        endcase
    endfunction

    localparam logic [5:0] ADDU = 6'h21, SUBU = 6'h23;
    localparam logic [5:0] ORI = 6'h0D, LW = 6'h23, SW = 6'h2B, BEQ = 6'h04;
    localparam logic [31:0] SENTINEL = 32'hDEAD_BEEF;

    int halt_idx;

    initial begin
        for (int i = 0; i < 128; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        for (int k = 0; k < 8; k++) begin
            dmem[2*k]   = op_a(k);
            dmem[2*k+1] = op_b(k);
        end
        dmem[83] = SENTINEL;

        // r10 = 0x140 (word 80), results reached with negative offsets
        emit(enc_i(ORI, 0, 10, 16'h0140));
        for (int k = 0; k < 8; k++) begin
            emit(enc_i(LW, 0, 1, 8*k));
            emit(enc_i(LW, 0, 2, 8*k + 4));
            emit(enc_r(1, 2, 3, ADDU));
            emit(enc_r(1, 2, 4, SUBU));
            emit(enc_i(SW, 10, 3, -64 + 8*k));
            emit(enc_i(SW, 10, 4, -60 + 8*k));
        end
        // zero extension of ori
        emit(enc_i(LW, 0, 2, 28));
        emit(enc_i(ORI, 2, 5, 16'h8001));
        emit(enc_i(SW, 10, 5, 0));
        // register 0
        emit(enc_i(ORI, 0, 0, 16'h1234));
        emit(enc_r(2, 2, 0, ADDU));
        emit(enc_i(SW, 10, 0, 4));
        // unknown encodings
        emit(enc_i(ORI, 0, 7, 16'h0055));
        emit(enc_i(6'h3F, 0, 7, 16'hFFFF));
        emit(enc_r(0, 0, 7, 6'h20));
        emit(enc_i(6'h2A, 10, 7, 12));
        emit(enc_i(SW, 10, 7, 8));
        // taken forward branch
        emit(enc_i(ORI, 0, 8, 1));
        emit(enc_i(ORI, 0, 11, 16'h0011));
        emit(enc_i(BEQ, 8, 8, 1));
        emit(enc_i(ORI, 0, 11, 16'h0BAD));
        emit(enc_i(SW, 10, 11, 16));
        // untaken branch
        emit(enc_i(ORI, 0, 12, 16'h0022));
        emit(enc_i(BEQ, 8, 0, 1));
        emit(enc_i(ORI, 0, 12, 16'h0077));
        emit(enc_i(SW, 10, 12, 20));
        // backward loop, three passes
        emit(enc_i(ORI, 0, 13, 3));
        emit(enc_i(ORI, 0, 14, 1));
        emit(enc_i(ORI, 0, 15, 0));
        emit(enc_r(13, 14, 13, SUBU));
        emit(enc_r(15, 14, 15, ADDU));
        emit(enc_i(BEQ, 13, 0, 1));
        emit(enc_i(BEQ, 0, 0, -4));
        emit(enc_i(SW, 10, 15, 24));
        // load through a negative offset
        emit(enc_i(LW, 10, 16, -64));
        emit(enc_i(SW, 10, 16, 28));
        halt_idx = pc_n;
        emit(enc_i(BEQ, 0, 0, -1));
    end

    initial begin
        int cyc;
        int still;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc after reset", imem_addr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 pc steps by four", imem_addr, 32'h4);

        cyc = 0;
        still = 0;
        while (still < 3 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (imem_addr == 32'(halt_idx * 4)) still++;
            else still = 0;
        end
        if (still < 3) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual pc %h expected %h", imem_addr, 32'(halt_idx * 4));
        end else begin
            check("R6 halt self-branch holds pc", imem_addr, 32'(halt_idx * 4));
        end

        for (int k = 0; k < 8; k++) begin
            check("R2 addu sum", dmem[64 + 2*k], op_a(k) + op_b(k));
            check("R2 subu difference", dmem[65 + 2*k], op_a(k) - op_b(k));
        end
        check("R3 ori zero-extends", dmem[80], op_b(3) | 32'h0000_8001);
        check("R7 register 0 stays zero", dmem[81], 32'h0);
        check("R8 unknown words leave register", dmem[82], 32'h0000_0055);
        check("R8 unknown word leaves memory", dmem[83], SENTINEL);
        check("R6 taken branch skips", dmem[84], 32'h0000_0011);
        check("R6 untaken branch falls through", dmem[85], 32'h0000_0077);
        check("R6 backward loop count", dmem[86], 32'h0000_0003);
        check("R4 load negative offset", dmem[87], op_a(0) + op_b(0));
        check("R5 store lands in slot", dmem[64], op_a(0) + op_b(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule